// File: doc/BRIEF.md
# Pixel-Matrix Cluster Finder

This block keeps a register replica of a pixel sensor, one small state register per pixel, and turns a scattered set of hit addresses into clusters of touching pixels. While idle it takes hit coordinates, one per cycle and in any order, and marks the addressed cells. A pulse on `load_done` starts processing. Processing picks a seed from the remaining hits, lets a "selected" flag spread from the seed to every touching hit, and streams the selected cells out as row/column beats. The final beat of each cluster is flagged. When no hits remain the core goes idle and accepts the next frame.

Spreading and readout run together, so a cluster leaves the core while it is still growing, and any shape works. Two priority chains choose the seed: one picks the column, one picks the row within that column. Another pair of chains chooses which selected cell goes on the output bus. Back-pressure on the output follows valid/ready rules. A beat is presented with `out_valid` and is consumed on a rising edge where `out_ready` is also high. While it waits, the beat and its fields do not change. The selection also does not spread while a beat waits, so a stall freezes the grid.

Top module: `cluster_finder`

## Requirements
- R1: After reset `busy` and `out_valid` are low and every cell is empty.
- R2: While `busy` is low, a cycle with `hit_valid` high marks cell (`hit_row`, `hit_col`) as hit. Row 0 is the top row and column 0 is the left column. Loading a cell that already holds a hit changes nothing, so duplicates give a single output beat.
- R3: A `load_done` pulse while idle raises `busy` from the next cycle on. `hit_valid` is ignored while `busy` is high.
- R4: The first beat of every cluster is its seed. The seed is the remaining hit in the lowest-numbered occupied column, taking the lowest row within that column. Clusters therefore come out in increasing order of (column, row) of their seeds.
- R5: A cluster holds exactly the hits reachable from its seed through side or corner neighbours (8-connectivity), and each of those hits appears exactly once.
- R6: `out_last` is high on the final beat of each cluster and low on every other beat.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_row`, `out_col` and `out_last` hold their values.
- R8: With `out_ready` held high, `busy` stays high for exactly H + K + 1 cycles for H distinct hits in K clusters. This means one seed cycle per cluster, one beat per cycle, and one final empty-seed cycle. The cycle after a cluster's last beat has `out_valid` low.
- R9: The beat sequence does not depend on the order in which hits were loaded.
- R10: `load_done` with an empty grid keeps `busy` high for exactly one cycle and produces no beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 1 | Load the addressed cell this cycle (idle only) |
| hit_row | input | $clog2(ROWS) | Row of the hit, 0 = top |
| hit_col | input | $clog2(COLS) | Column of the hit, 0 = left |
| load_done | input | 1 | Frame loaded; start clustering |
| busy | output | 1 | High while clusters are being formed or read out |
| out_valid | output | 1 | A cluster cell is presented |
| out_ready | input | 1 | Downstream accepts the presented cell |
| out_row | output | $clog2(ROWS) | Row of the presented cell |
| out_col | output | $clog2(COLS) | Column of the presented cell |
| out_last | output | 1 | Presented cell is the final one of its cluster |

## Verification
The hardest situation to reach is a stall while the cluster is still growing. In that case selected and still-unselected hits sit side by side, and any spreading during the stall would change which cell the readout chain presents. The bench loads irregular shapes: a U, a corner-linked diagonal, and a line across all columns. It then drains them with a pseudo-random `out_ready` pattern, so stalls land in mid-growth. It checks that held beats stay frozen and that the clusters still match a flood-fill model. Load-order independence is tested by replaying the same frame with the hits loaded in reverse order.

// File: rtl/clu_pkg.sv
package clu_pkg;
  typedef enum logic [1:0] {
    CELL_EMPTY = 2'b00,
    CELL_HIT   = 2'b01,
    CELL_SEL   = 2'b10
  } cell_e;

  typedef enum logic [1:0] {
    ST_LOAD = 2'b00,
    ST_SEED = 2'b01,
    ST_READ = 2'b10
  } ctrl_e;
endpackage

// File: rtl/clu_prio_pick.sv
// Priority chain: index of the lowest set bit of vec.
module clu_prio_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/clu_cell_array.sv
// Grid of three-state cells; flat index = col*ROWS + row.
module clu_cell_array
  import clu_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int N  = ROWS * COLS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [RW-1:0] load_row,
  input  logic [CW-1:0] load_col,
  input  logic          seed_en,
  input  logic [RW-1:0] seed_row,
  input  logic [CW-1:0] seed_col,
  input  logic          take_en,
  input  logic [RW-1:0] take_row,
  input  logic [CW-1:0] take_col,
  input  logic          grow_en,
  output logic [N-1:0]  hit_map,
  output logic [N-1:0]  sel_map,
  output logic          grow_any
);
  logic [N-1:0] grow_map;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int K = c * ROWS + r;
      cell_e cell_q;
      logic  nb_sel;
      logic  ld_hit, sd_hit, tk_hit;

      assign ld_hit = (load_row == RW'(r)) && (load_col == CW'(c));
      assign sd_hit = (seed_row == RW'(r)) && (seed_col == CW'(c));
      assign tk_hit = (take_row == RW'(r)) && (take_col == CW'(c));

      // any of the eight neighbours selected
      always_comb begin
        nb_sel = 1'b0;
        for (int dc = -1; dc <= 1; dc++) begin
          for (int dr = -1; dr <= 1; dr++) begin
            if (!(dr == 0 && dc == 0) &&
                (r + dr >= 0) && (r + dr < ROWS) &&
                (c + dc >= 0) && (c + dc < COLS)) begin
              nb_sel = nb_sel | sel_map[(c + dc) * ROWS + (r + dr)];
            end
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cell_q <= CELL_EMPTY;
        end else begin
          case (cell_q)
            CELL_EMPTY: if (load_en && ld_hit) cell_q <= CELL_HIT;
            CELL_HIT:   if ((seed_en && sd_hit) || (grow_en && nb_sel)) cell_q <= CELL_SEL;
            CELL_SEL:   if (take_en && tk_hit) cell_q <= CELL_EMPTY;
            default:    cell_q <= CELL_EMPTY;
          endcase
        end
      end

      assign hit_map[K]  = (cell_q == CELL_HIT);
      assign sel_map[K]  = (cell_q == CELL_SEL);
      assign grow_map[K] = (cell_q == CELL_HIT) && nb_sel;
    end
  end

  assign grow_any = |grow_map;
endmodule

// File: rtl/cluster_finder.sv
module cluster_finder
  import clu_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int N  = ROWS * COLS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_valid,
  input  logic [RW-1:0] hit_row,
  input  logic [CW-1:0] hit_col,
  input  logic          load_done,
  output logic          busy,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output logic          out_last
);
  ctrl_e         state_q;
  logic [N-1:0]  hit_map, sel_map;
  logic          grow_any;
  logic [COLS-1:0] col_hit, col_sel;
  logic [ROWS-1:0] seed_rows, rd_rows;
  logic          any_hit, any_sel, seed_row_any, rd_row_any;
  logic [CW-1:0] seed_c, rd_c;
  logic [RW-1:0] seed_r, rd_r;
  logic          take, only_one;

  for (genvar c = 0; c < COLS; c++) begin : g_color
    assign col_hit[c] = |hit_map[c*ROWS +: ROWS];
    assign col_sel[c] = |sel_map[c*ROWS +: ROWS];
  end

  // column chains
  clu_prio_pick #(.N(COLS)) u_seed_col (.vec(col_hit), .any(any_hit), .idx(seed_c));
  clu_prio_pick #(.N(COLS)) u_rd_col   (.vec(col_sel), .any(any_sel), .idx(rd_c));

  always_comb begin
    seed_rows = '0;
    rd_rows   = '0;
    for (int c = 0; c < COLS; c++) begin
      if (CW'(c) == seed_c) seed_rows = hit_map[c*ROWS +: ROWS];
      if (CW'(c) == rd_c)   rd_rows   = sel_map[c*ROWS +: ROWS];
    end
  end

  // row chains
  clu_prio_pick #(.N(ROWS)) u_seed_row (.vec(seed_rows), .any(seed_row_any), .idx(seed_r));
  clu_prio_pick #(.N(ROWS)) u_rd_row   (.vec(rd_rows),   .any(rd_row_any),   .idx(rd_r));

  assign out_valid = (state_q == ST_READ) && any_sel && rd_row_any;
  assign out_row   = rd_r;
  assign out_col   = rd_c;
  assign only_one  = any_sel && ((sel_map & (sel_map - N'(1))) == '0);
  assign out_last  = only_one && !grow_any;
  assign take      = out_valid && out_ready;
  assign busy      = (state_q != ST_LOAD);

  clu_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_grid (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  ((state_q == ST_LOAD) && hit_valid),
    .load_row (hit_row),
    .load_col (hit_col),
    .seed_en  ((state_q == ST_SEED) && seed_row_any),
    .seed_row (seed_r),
    .seed_col (seed_c),
    .take_en  (take),
    .take_row (rd_r),
    .take_col (rd_c),
    .grow_en  (take),
    .hit_map  (hit_map),
    .sel_map  (sel_map),
    .grow_any (grow_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
    end else begin
      case (state_q)
        ST_LOAD: if (load_done) state_q <= ST_SEED;
        ST_SEED: state_q <= any_hit ? ST_READ : ST_LOAD;
        ST_READ: if (take && out_last) state_q <= ST_SEED;
        default: state_q <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/cluster_finder_chk.sv
module cluster_finder_chk #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_done,
  input logic          busy,
  input logic          out_valid,
  input logic          out_ready,
  input logic [RW-1:0] out_row,
  input logic [CW-1:0] out_col,
  input logic          out_last
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_col) && $stable(out_last));

  // R8
  last_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && load_done |=> busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  // R10
  idle_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !out_valid);
endmodule

bind cluster_finder cluster_finder_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_done(load_done), .busy(busy),
  .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
  .out_col(out_col), .out_last(out_last)
);

// File: tb/test_cluster_finder.sv
module test_cluster_finder;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 16;
  localparam int COLS = 8;
  localparam int N = ROWS * COLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit_valid = 1'b0;
  logic [3:0] hit_row = '0;
  logic [2:0] hit_col = '0;
  logic load_done = 1'b0;
  logic busy, out_valid, out_last;
  logic out_ready = 1'b1;
  logic [3:0] out_row;
  logic [2:0] out_col;

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_finder #(.ROWS(ROWS), .COLS(COLS)) i_cluster_finder (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_row(hit_row),
    .hit_col(hit_col), .load_done(load_done), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .out_col(out_col), .out_last(out_last)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bit mdl[N];
  int lbl[N];
  int lst_r[64], lst_c[64];
  int lst_n = 0;
  int bt[256];
  bit bl[256];
  int nbt = 0;
  int sav_bt[256];
  int sav_n;
  logic [7:0] lfsr = 8'h5A;
  bit poke = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add(input int r, input int c);
    lst_r[lst_n] = r;
    lst_c[lst_n] = c;
    lst_n++;
  endtask

  task automatic load_list(input bit rev);
    for (int i = 0; i < lst_n; i++) begin
      int k = rev ? lst_n - 1 - i : i;
      hit_valid = 1'b1;
      hit_row = 4'(lst_r[k]);
      hit_col = 3'(lst_c[k]);
      mdl[lst_c[k]*ROWS + lst_r[k]] = 1'b1;
      @(negedge clk);
    end
    hit_valid = 1'b0;
  endtask

  // flood-fill labels: each hit gets the lowest index of its component
  task automatic label();
    bit changed;
    for (int i = 0; i < N; i++) lbl[i] = mdl[i] ? i : -1;
    changed = 1'b1;
    while (changed) begin
      changed = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (mdl[i]) begin
          int r = i % ROWS;
          int c = i / ROWS;
          for (int dc = -1; dc <= 1; dc++)
            for (int dr = -1; dr <= 1; dr++) begin
              int rr = r + dr;
              int cc = c + dc;
              if (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS && mdl[cc*ROWS+rr]
                  && lbl[cc*ROWS+rr] < lbl[i]) begin
                lbl[i] = lbl[cc*ROWS+rr];
                changed = 1'b1;
              end
            end
        end
      end
    end
  endtask

  // start processing and drain; mode 0 = ready always high, 1 = random stalls
  task automatic run(input int mode, output int cycles);
    bit held = 1'b0;
    logic [3:0] h_r;
    logic [2:0] h_c;
    logic h_l;
    nbt = 0;
    cycles = 0;
    load_done = 1'b1;
    @(negedge clk);
    load_done = 1'b0;
    while (busy && cycles < 4000) begin
      cycles++;
      if (poke && cycles == 2) begin
        hit_valid = 1'b1; hit_row = 4'd9; hit_col = 3'd6;
      end
      if (poke && cycles == 3) hit_valid = 1'b0;
      if (held) begin
        check(out_valid && out_row == h_r && out_col == h_c && out_last == h_l,
              "R7", "held beat changed", {out_col, out_row}, {h_c, h_r});
      end
      if (mode == 0) out_ready = 1'b1;
      else begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = lfsr[0] & lfsr[2];
      end
      if (out_valid && out_ready && nbt < 256) begin
        bt[nbt] = int'(out_col) * ROWS + int'(out_row);
        bl[nbt] = out_last;
        nbt++;
      end
      held = out_valid && !out_ready;
      h_r = out_row; h_c = out_col; h_l = out_last;
      @(negedge clk);
    end
    hit_valid = 1'b0;
    out_ready = 1'b1;
  endtask

  // compare captured beats against the model; returns hits and clusters
  task automatic verify(output int hits, output int clus);
    int p = 0;
    label();
    hits = 0;
    clus = 0;
    for (int s = 0; s < N; s++) begin
      if (mdl[s]) hits++;
      if (mdl[s] && lbl[s] == s) begin
        int size = 0;
        bit ok_mem = 1'b1, ok_last = 1'b1;
        clus++;
        for (int i = 0; i < N; i++) if (lbl[i] == s) size++;
        if (p < nbt) check(bt[p] == s, "R4", "cluster seed", bt[p], s);
        for (int j = 0; j < size; j++) begin
          if (p + j < nbt) begin
            if (lbl[bt[p+j]] != s) ok_mem = 1'b0;
            if (bl[p+j] != (j == size - 1)) ok_last = 1'b0;
          end else ok_mem = 1'b0;
        end
        check(ok_mem, "R5", "cluster membership at seed", s, s);
        check(ok_last, "R6", "last marker at seed", s, s);
        p += size;
      end
    end
    check(p == nbt, "R5", "total beats", nbt, p);
    for (int i = 0; i < nbt; i++)
      for (int j = i + 1; j < nbt; j++)
        if (bt[i] == bt[j]) check(1'b0, "R5", "duplicate beat", bt[j], -1);
    for (int i = 0; i < N; i++) mdl[i] = 1'b0;
    lst_n = 0;
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_empty();
    int cyc, h, k;
    run(0, cyc);
    check(cyc == 1, "R10", "busy cycles on empty grid", cyc, 1);
    check(nbt == 0, "R10", "beats on empty grid", nbt, 0);
    verify(h, k);
  endtask

  task automatic t_single();
    int cyc, h, k;
    add(0, 0);
    load_list(1'b0);
    run(0, cyc);
    check(nbt == 1 && bl[0], "R6", "single cell last", int'(bl[0]), 1);
    verify(h, k);
    check(cyc == h + k + 1, "R8", "busy cycles single", cyc, h + k + 1);
  endtask

  task automatic build_shapes();
    add(2, 1); add(3, 1); add(4, 1); add(4, 2); add(4, 3); add(3, 3); add(2, 3);
    add(7, 0); add(8, 1); add(9, 2); add(10, 3);
    add(15, 7); add(0, 7); add(1, 6);
    for (int c = 0; c < COLS; c++) add(13, c);
    add(11, 4);
    add(14, 0);
  endtask

  task automatic t_shapes();
    int cyc, h, k;
    build_shapes();
    load_list(1'b0);
    run(0, cyc);
    verify(h, k);
    check(cyc == h + k + 1, "R8", "busy cycles shapes", cyc, h + k + 1);
  endtask

  task automatic t_backpressure();
    int cyc, h, k;
    build_shapes();
    load_list(1'b1);
    run(1, cyc);
    verify(h, k);
    check(cyc > h + k + 1, "R7", "stalls lengthened run", cyc, h + k + 2);
  endtask

  task automatic t_order();
    int cyc, h, k;
    bit same;
    build_shapes();
    load_list(1'b0);
    run(0, cyc);
    sav_n = nbt;
    for (int i = 0; i < nbt; i++) sav_bt[i] = bt[i];
    verify(h, k);
    build_shapes();
    load_list(1'b1);
    run(0, cyc);
    same = (nbt == sav_n);
    for (int i = 0; i < nbt && i < sav_n; i++) if (bt[i] != sav_bt[i]) same = 1'b0;
    check(same, "R9", "reverse-order beat sequence", nbt, sav_n);
    verify(h, k);
  endtask

  task automatic t_dup();
    int cyc, h, k;
    add(6, 2); add(6, 2); add(7, 3); add(6, 2);
    load_list(1'b0);
    run(0, cyc);
    check(nbt == 2, "R2", "duplicate hits merged", nbt, 2);
    verify(h, k);
    check(cyc == 4, "R8", "busy cycles dup", cyc, 4);
  endtask

  task automatic t_busy_ignore();
    int cyc, h, k;
    add(5, 5); add(5, 4);
    load_list(1'b0);
    poke = 1'b1;
    run(0, cyc);
    poke = 1'b0;
    verify(h, k);
    run(0, cyc);
    check(cyc == 1 && nbt == 0, "R3", "hit during busy ignored", nbt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_single();
    t_shapes();
    t_dup();
    t_order();
    t_backpressure();
    t_busy_ignore();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule